// File: doc/BRIEF.md
# Out-of-Order Multi-Channel Issue Scheduler

This block is the instruction window that sits between decode and the execution units of an out-of-order core. Decoded instructions enter it in groups of up to four per cycle. Each one is written into a 16-slot circular buffer at the allocation pointer. Each stored entry records whether it is live, whether it has already been sent to a unit, its instruction group, a readiness flag for each of its two source registers, the register numbers of those sources and its destination tag.

Every cycle the block offers work to six execution channels: two simple-ALU channels, one complex-ALU channel that also takes multiplies, one branch channel and two address-generation channels. For each channel it walks the window from the oldest slot toward the youngest. The first entry that can go wins, even when older entries of the same kind are still waiting for operands. Destination tags written back by the execution units wake up matching sources. Completion feedback, given as a slot number, kills an entry. The oldest pointer then moves over the dead slots at the front of the window, and this returns space for new instructions.

Top module: `issue_sched`

## Requirements
- R1: After synchronous reset the window is empty. `free_slots` reads 16, `in_ready` is 1 and no `iss_valid` bit is set. This holds even if reset arrives while the window is full.
- R2: Only input slots with `in_valid` set take an entry. The k-th valid slot, counted in increasing slot order, is written to position (allocation pointer + k) mod 16. `free_slots` drops by the number of accepted instructions at the next clock edge.
- R3: `in_ready` is 0 whenever `free_slots` is below the number of set `in_valid` bits. In that case the whole group is refused and nothing is written. `in_ready` is 1 otherwise.
- R4: An entry is offered to a channel only if it is live, not yet issued, and has both source-ready flags set. Grants are combinational from the stored state, so an entry is first offered in the cycle after it is inserted.
- R5: Each channel grants the first eligible entry found when scanning circularly from the oldest live position, wrapping past slot 15. A ready younger entry is granted ahead of an older stalled one.
- R6: The second simple-ALU channel (`iss_valid[1]`) takes the second eligible simple entry in age order, and the second address channel (`iss_valid[5]`) takes the second eligible load. Neither is granted unless its first channel (bit 0 or bit 4) is granted in the same cycle. The oldest entry can therefore never go to a second channel.
- R7: A granted entry is marked issued at the next edge and is never granted again. It stays resident, and `free_slots` does not change, until completion feedback arrives for its slot.
- R8: A completion on `done_valid`/`done_idx` kills that slot at the next edge. One cycle after that, the oldest pointer skips every contiguous dead slot at the front, and `free_slots` rises by that amount. A dead slot behind a live older entry frees nothing.
- R9: A writeback with `wb_valid` set and tag T sets the ready flag of every live source whose register equals T. This includes instructions being inserted in the same cycle.
- R10: A branch-group instruction is stored with its second source ready, whatever `in_rdy_b` says.
- R11: The group codes are ADD=0 and SHIFT=1 (simple), MUL=2 and CMOV=3 (complex), BEQ=4 (branch), and LD=5 (address). The channel bits of `iss_valid`/`iss_idx`/`iss_dst` are 0=SA0, 1=SA1, 2=CA, 3=BR, 4=AG0 and 5=AG1. `iss_idx` gives the slot number and `iss_dst` gives the destination tag of the granted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-slot valid for the incoming group |
| in_grp | input | 4x3 | Instruction group code per slot |
| in_src_a | input | 4x6 | First source register per slot |
| in_src_b | input | 4x6 | Second source register per slot |
| in_rdy_a | input | 4 | First source already ready |
| in_rdy_b | input | 4 | Second source already ready |
| in_dst | input | 4x6 | Destination tag per slot |
| in_ready | output | 1 | Group accepted this cycle |
| free_slots | output | 5 | Number of unallocated window positions |
| wb_valid | input | 2 | Writeback broadcast valid |
| wb_tag | input | 2x6 | Writeback destination register |
| done_valid | input | 2 | Completion feedback valid |
| done_idx | input | 2x4 | Slot number being completed |
| iss_valid | output | 6 | Grant per channel |
| iss_idx | output | 6x4 | Granted slot per channel |
| iss_dst | output | 6x6 | Destination tag of granted entry per channel |

## Verification
A table of single-cycle insert patterns checks each group mapping. The patterns are four simple ops, four loads, one of each kind, a lone conditional move among invalid slots, and a group with a leading hole. Together they separate a wrong channel mapping, a wrong pairing of the second channels and a wrong compaction of invalid slots. Directed sequences then stall an old entry behind younger ready ones. They also fill the window and wrap the allocation pointer, so that a linear rather than circular age scan gives the wrong winner. Wakeup is tried both on stored and on just-inserted entries. Completion is given both out of order and at the front, to tell head skipping apart from plain counting.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;

    typedef enum logic [2:0] {
        GRP_ADD   = 3'd0,
        GRP_SHIFT = 3'd1,
        GRP_MUL   = 3'd2,
        GRP_CMOV  = 3'd3,
        GRP_BEQ   = 3'd4,
        GRP_LD    = 3'd5
    } grp_e;

    // channel positions on the grant vectors
    localparam int NCH     = 6;
    localparam int CH_SA0  = 0;
    localparam int CH_SA1  = 1;
    localparam int CH_CA   = 2;
    localparam int CH_BR   = 3;
    localparam int CH_AG0  = 4;
    localparam int CH_AG1  = 5;

    // execution classes: each class owns a contiguous run of channels
    localparam int NCLS        = 4;
    localparam int CLS_SIMPLE  = 0;
    localparam int CLS_COMPLEX = 1;
    localparam int CLS_BRANCH  = 2;
    localparam int CLS_ADDR    = 3;
    localparam int CLS_NONE    = 4;

    function automatic int cls_of(logic [2:0] g);
        case (g)
            GRP_ADD, GRP_SHIFT: return CLS_SIMPLE;
            GRP_MUL, GRP_CMOV:  return CLS_COMPLEX;
            GRP_BEQ:            return CLS_BRANCH;
            GRP_LD:             return CLS_ADDR;
            default:            return CLS_NONE;
        endcase
    endfunction

    function automatic int cls_npick(int c);
        return (c == CLS_SIMPLE || c == CLS_ADDR) ? 2 : 1;
    endfunction

    function automatic int cls_base(int c);
        case (c)
            CLS_SIMPLE:  return CH_SA0;
            CLS_COMPLEX: return CH_CA;
            CLS_BRANCH:  return CH_BR;
            default:     return CH_AG0;
        endcase
    endfunction

endpackage

// File: rtl/issue_sched_alloc.sv
// Compacts the valid input slots onto consecutive window positions.
module issue_sched_alloc #(
    parameter int IN_W = 4,
    parameter int IW   = 4,
    localparam int NW  = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]         in_valid,
    input  logic [IW-1:0]           tail,
    output logic [IN_W-1:0][IW-1:0] slot_idx,
    output logic [NW-1:0]           n_valid
);
    logic [NW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int s = 0; s < IN_W; s++) begin
            slot_idx[s] = tail + IW'(cnt);
            if (in_valid[s]) cnt = cnt + NW'(1);
        end
        n_valid = cnt;
    end
endmodule

// File: rtl/issue_sched_pick.sv
// Age-ordered selector: returns the first NPICK eligible slots from head.
module issue_sched_pick #(
    parameter int DEPTH = 16,
    parameter int IW    = 4,
    parameter int NPICK = 2
) (
    input  logic [DEPTH-1:0]         elig,
    input  logic [IW-1:0]            head,
    output logic [NPICK-1:0]         pick_v,
    output logic [NPICK-1:0][IW-1:0] pick_idx
);
    logic [IW-1:0] pos;
    int            nf;

    always_comb begin
        pick_v   = '0;
        pick_idx = '0;
        nf       = 0;
        pos      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            pos = head + IW'(k);
            if (elig[pos]) begin
                for (int n = 0; n < NPICK; n++) begin
                    if (n == nf) begin
                        pick_v[n]   = 1'b1;
                        pick_idx[n] = pos;
                    end
                end
                nf = nf + 1;
            end
        end
    end
endmodule

// File: rtl/issue_sched_headadv.sv
// Counts dead slots at the front of the occupied region.
module issue_sched_headadv #(
    parameter int DEPTH = 16,
    parameter int IW    = 4,
    parameter int CW    = 5
) (
    input  logic [DEPTH-1:0] live,
    input  logic [IW-1:0]    head,
    input  logic [CW-1:0]    count,
    output logic [CW-1:0]    adv
);
    logic          run;
    logic [IW-1:0] pos;

    always_comb begin
        adv = '0;
        run = 1'b1;
        pos = '0;
        for (int k = 0; k < DEPTH; k++) begin
            pos = head + IW'(k);
            if (run && (CW'(k) < count) && !live[pos])
                adv = adv + CW'(1);
            else
                run = 1'b0;
        end
    end
endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import issue_sched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IN_W  = 4,
    parameter int RW    = 6,
    parameter int NWB   = 2,
    parameter int NDONE = 2,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(IN_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IN_W-1:0]          in_valid,
    input  logic [IN_W-1:0][2:0]     in_grp,
    input  logic [IN_W-1:0][RW-1:0]  in_src_a,
    input  logic [IN_W-1:0][RW-1:0]  in_src_b,
    input  logic [IN_W-1:0]          in_rdy_a,
    input  logic [IN_W-1:0]          in_rdy_b,
    input  logic [IN_W-1:0][RW-1:0]  in_dst,
    output logic                     in_ready,
    output logic [CW-1:0]            free_slots,
    input  logic [NWB-1:0]           wb_valid,
    input  logic [NWB-1:0][RW-1:0]   wb_tag,
    input  logic [NDONE-1:0]         done_valid,
    input  logic [NDONE-1:0][IW-1:0] done_idx,
    output logic [NCH-1:0]           iss_valid,
    output logic [NCH-1:0][IW-1:0]   iss_idx,
    output logic [NCH-1:0][RW-1:0]   iss_dst
);
    typedef struct packed {
        logic          live;
        logic          issued;
        logic [2:0]    grp;
        logic          rdy_a;
        logic          rdy_b;
        logic [RW-1:0] src_a;
        logic [RW-1:0] src_b;
        logic [RW-1:0] dst;
    } ent_t;

    ent_t ent   [DEPTH];
    ent_t ent_n [DEPTH];

    logic [IW-1:0]           head, tail;
    logic [CW-1:0]           count, adv;
    logic [IN_W-1:0][IW-1:0] slot_idx;
    logic [NW-1:0]           n_in;
    logic [DEPTH-1:0]        live_vec;
    logic [NCLS-1:0][DEPTH-1:0] elig;

    issue_sched_alloc #(.IN_W(IN_W), .IW(IW)) alloc_i (
        .in_valid (in_valid),
        .tail     (tail),
        .slot_idx (slot_idx),
        .n_valid  (n_in)
    );

    issue_sched_headadv #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) headadv_i (
        .live  (live_vec),
        .head  (head),
        .count (count),
        .adv   (adv)
    );

    assign free_slots = CW'(DEPTH) - count;
    assign in_ready   = (CW'(n_in) <= free_slots);

    // eligibility per class
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live_vec[i] = ent[i].live;
            for (int c = 0; c < NCLS; c++)
                elig[c][i] = ent[i].live && !ent[i].issued && ent[i].rdy_a &&
                             ent[i].rdy_b && (cls_of(ent[i].grp) == c);
        end
    end

    // one selector per class drives that class's run of channels
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam int NP = cls_npick(c);
        localparam int CB = cls_base(c);
        issue_sched_pick #(.DEPTH(DEPTH), .IW(IW), .NPICK(NP)) pick_i (
            .elig     (elig[c]),
            .head     (head),
            .pick_v   (iss_valid[CB+NP-1:CB]),
            .pick_idx (iss_idx[CB+NP-1:CB])
        );
    end

    always_comb begin
        for (int c = 0; c < NCH; c++)
            iss_dst[c] = ent[iss_idx[c]].dst;
    end

    // next-state of the window: wakeup, issue marking, completion, insert
    always_comb begin
        ent_t e;
        for (int i = 0; i < DEPTH; i++) begin
            e = ent[i];
            for (int j = 0; j < NWB; j++) begin
                if (wb_valid[j] && e.live) begin
                    if (e.src_a == wb_tag[j]) e.rdy_a = 1'b1;
                    if (e.src_b == wb_tag[j]) e.rdy_b = 1'b1;
                end
            end
            for (int c = 0; c < NCH; c++)
                if (iss_valid[c] && iss_idx[c] == IW'(i)) e.issued = 1'b1;
            for (int k = 0; k < NDONE; k++)
                if (done_valid[k] && done_idx[k] == IW'(i)) e.live = 1'b0;
            ent_n[i] = e;
        end
        if (in_ready) begin
            for (int s = 0; s < IN_W; s++) begin
                if (in_valid[s]) begin
                    e.live   = 1'b1;
                    e.issued = 1'b0;
                    e.grp    = in_grp[s];
                    e.rdy_a  = in_rdy_a[s];
                    e.rdy_b  = in_rdy_b[s] || (in_grp[s] == GRP_BEQ);
                    e.src_a  = in_src_a[s];
                    e.src_b  = in_src_b[s];
                    e.dst    = in_dst[s];
                    for (int j = 0; j < NWB; j++) begin
                        if (wb_valid[j] && in_src_a[s] == wb_tag[j]) e.rdy_a = 1'b1;
                        if (wb_valid[j] && in_src_b[s] == wb_tag[j]) e.rdy_b = 1'b1;
                    end
                    ent_n[slot_idx[s]] = e;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= ent_n[i];
            head  <= head + IW'(adv);
            tail  <= tail + (in_ready ? IW'(n_in) : IW'(0));
            count <= count - adv + (in_ready ? CW'(n_in) : CW'(0));
        end
    end
endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk #(
    parameter int DEPTH = 16,
    parameter int IN_W  = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [IN_W-1:0]     in_valid,
    input logic                in_ready,
    input logic [CW-1:0]       free_slots,
    input logic [5:0]          iss_valid,
    input logic [5:0][IW-1:0]  iss_idx
);
    // R1: reset empties the window and silences every channel
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (free_slots == CW'(DEPTH)) && (iss_valid == '0));

    // R2 and R3: free space only shrinks by what was accepted
    a_r2_free_accounting: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(free_slots) + ($past(in_ready) ? $countones($past(in_valid)) : 0))
                 >= int'($past(free_slots)));

    // R3: a refused group leaves free space untouched or growing
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> free_slots >= $past(free_slots));

    // R6: second simple channel only alongside the first, on another slot
    a_r6_sa_pairing: assert property (@(posedge clk) disable iff (rst)
        iss_valid[1] |-> iss_valid[0] && (iss_idx[1] != iss_idx[0]));

    // R6: second address channel only alongside the first, on another slot
    a_r6_ag_pairing: assert property (@(posedge clk) disable iff (rst)
        iss_valid[5] |-> iss_valid[4] && (iss_idx[5] != iss_idx[4]));

    // R7: a granted slot is not granted again on the next cycle
    for (genvar c = 0; c < 6; c++) begin : g_regrant
        a_r7_no_regrant: assert property (@(posedge clk) disable iff (rst)
            iss_valid[c] |=> !(iss_valid[c] && iss_idx[c] == $past(iss_idx[c])));
    end
endmodule

bind issue_sched issue_sched_chk #(.DEPTH(DEPTH), .IN_W(IN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .free_slots (free_slots),
    .iss_valid  (iss_valid),
    .iss_idx    (iss_idx)
);

// File: tb/issue_sched_tb_top.sv
module issue_sched_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic [3:0]       in_valid;
    logic [3:0][2:0]  in_grp;
    logic [3:0][5:0]  in_src_a, in_src_b, in_dst;
    logic [3:0]       in_rdy_a, in_rdy_b;
    logic             in_ready;
    logic [4:0]       free_slots;
    logic [1:0]       wb_valid;
    logic [1:0][5:0]  wb_tag;
    logic [1:0]       done_valid;
    logic [1:0][3:0]  done_idx;
    logic [5:0]       iss_valid;
    logic [5:0][3:0]  iss_idx;
    logic [5:0][5:0]  iss_dst;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    issue_sched dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_grp(in_grp), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_rdy_a(in_rdy_a), .in_rdy_b(in_rdy_b), .in_dst(in_dst),
        .in_ready(in_ready), .free_slots(free_slots),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .done_valid(done_valid), .done_idx(done_idx),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_dst(iss_dst)
    );

    // group codes: 0 ADD, 1 SHIFT, 2 MUL, 3 CMOV, 4 BEQ, 5 LD
    typedef struct packed {
        logic [3:0]      v;
        logic [3:0][2:0] g;
        logic [5:0]      m;
        logic [5:0][3:0] ix;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{4'b1111, {3'd0, 3'd0, 3'd0, 3'd0}, 6'b000011, 24'h000010},
        '{4'b1111, {3'd5, 3'd5, 3'd5, 3'd5}, 6'b110000, 24'h100000},
        '{4'b1111, {3'd0, 3'd5, 3'd4, 3'd2}, 6'b011101, 24'h021003},
        '{4'b0100, {3'd0, 3'd3, 3'd0, 3'd0}, 6'b000100, 24'h000000},
        '{4'b1110, {3'd0, 3'd5, 3'd1, 3'd0}, 6'b010011, 24'h010020},
        '{4'b0000, {3'd0, 3'd0, 3'd0, 3'd0}, 6'b000000, 24'h000000}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        in_valid = '0; in_grp = '0; in_src_a = '0; in_src_b = '0;
        in_rdy_a = '0; in_rdy_b = '0; in_dst = '0;
        wb_valid = '0; wb_tag = '0; done_valid = '0; done_idx = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
        clr_in();
    endtask

    task automatic put(input int s, input logic [2:0] g, input logic ra, input logic rb,
                       input logic [5:0] sa, input logic [5:0] d);
        in_valid[s] = 1'b1; in_grp[s] = g; in_rdy_a[s] = ra; in_rdy_b[s] = rb;
        in_src_a[s] = sa; in_src_b[s] = 6'd0; in_dst[s] = d;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clr_in();
        cyc();
        cyc();
        rst = 1'b0;
    endtask

    task automatic fill_stalled(input logic [5:0] sa);
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 4; s++) put(s, 3'd0, 1'b0, 1'b1, sa, 6'd0);
            cyc();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        clr_in();
        do_reset();
        chk("R1 free after reset", free_slots, 16);
        chk("R1 ready after reset", in_ready, 1);
        chk("R1 no grants after reset", iss_valid, 0);

        // table of single-group patterns (R2, R5, R6, R11)
        for (int t = 0; t < 6; t++) begin
            do_reset();
            in_valid = VT[t].v;
            for (int s = 0; s < 4; s++) begin
                in_grp[s] = VT[t].g[s];
                in_rdy_a[s] = 1'b1;
                in_rdy_b[s] = 1'b1;
            end
            #1;
            chk("R3 group fits", in_ready, 1);
            cyc();
            chk("R2 free after insert", free_slots, 16 - $countones(VT[t].v));
            chk("R11 channel mask", iss_valid, VT[t].m);
            for (int c = 0; c < 6; c++)
                if (VT[t].m[c]) chk("R11 granted slot", iss_idx[c], VT[t].ix[c]);
        end

        // R4 and R9: stored wakeup
        do_reset();
        put(0, 3'd0, 1'b0, 1'b1, 6'd5, 6'd33);
        cyc();
        chk("R4 stalled source blocks", iss_valid, 0);
        wb_valid[0] = 1'b1; wb_tag[0] = 6'd5;
        cyc();
        chk("R9 wakeup grants SA0", iss_valid[0], 1);
        chk("R9 wakeup slot", iss_idx[0], 0);
        chk("R11 destination tag", iss_dst[0], 33);
        cyc();
        chk("R7 issued not regranted", iss_valid, 0);
        chk("R7 issued stays resident", free_slots, 15);

        // R9: wakeup in the insertion cycle
        do_reset();
        put(0, 3'd0, 1'b0, 1'b1, 6'd7, 6'd1);
        wb_valid[1] = 1'b1; wb_tag[1] = 6'd7;
        cyc();
        chk("R9 same-cycle wakeup", iss_valid[0], 1);

        // R10: branch second source forced ready
        do_reset();
        put(0, 3'd4, 1'b1, 1'b0, 6'd0, 6'd2);
        cyc();
        chk("R10 branch granted", iss_valid[3], 1);

        // R5: younger ready ops pass a stalled older one
        do_reset();
        put(0, 3'd0, 1'b0, 1'b1, 6'd12, 6'd0);
        put(1, 3'd0, 1'b1, 1'b1, 6'd0, 6'd0);
        put(2, 3'd1, 1'b1, 1'b1, 6'd0, 6'd0);
        cyc();
        chk("R5 SA0 skips stalled head", iss_idx[0], 1);
        chk("R5 SA1 next eligible", iss_idx[1], 2);
        chk("R5 both simple granted", iss_valid[1:0], 3);

        // R6: lone simple op not at head goes to SA0 only
        do_reset();
        put(0, 3'd5, 1'b1, 1'b1, 6'd0, 6'd0);
        put(1, 3'd0, 1'b1, 1'b1, 6'd0, 6'd0);
        cyc();
        chk("R6 SA1 idle with one simple", iss_valid[1], 0);
        chk("R6 SA0 takes slot 1", iss_idx[0], 1);

        // R7 and R8: repeated issue, holes, head skip
        do_reset();
        for (int s = 0; s < 3; s++) put(s, 3'd5, 1'b1, 1'b1, 6'd0, 6'd0);
        cyc();
        chk("R6 AG pair mask", iss_valid, 6'b110000);
        chk("R6 AG1 slot", iss_idx[5], 1);
        cyc();
        chk("R7 third load next cycle", iss_valid, 6'b010000);
        chk("R7 third load slot", iss_idx[4], 2);
        cyc();
        chk("R7 nothing left to grant", iss_valid, 0);
        chk("R7 entries resident", free_slots, 13);
        done_valid[0] = 1'b1; done_idx[0] = 4'd1;
        cyc();
        cyc();
        chk("R8 hole behind live head frees nothing", free_slots, 13);
        done_valid[0] = 1'b1; done_idx[0] = 4'd0;
        cyc();
        chk("R8 release lags deletion", free_slots, 13);
        cyc();
        chk("R8 head skips two dead slots", free_slots, 15);

        // R3: backpressure
        do_reset();
        fill_stalled(6'd40);
        chk("R3 full window", free_slots, 0);
        put(0, 3'd0, 1'b1, 1'b1, 6'd0, 6'd0);
        #1;
        chk("R3 refuse when full", in_ready, 0);
        cyc();
        chk("R3 refused group not written", free_slots, 0);
        do_reset();
        for (int r = 0; r < 3; r++) begin
            for (int s = 0; s < 4; s++) put(s, 3'd0, 1'b0, 1'b1, 6'd40, 6'd0);
            cyc();
        end
        put(0, 3'd0, 1'b0, 1'b1, 6'd40, 6'd0);
        put(1, 3'd0, 1'b0, 1'b1, 6'd40, 6'd0);
        cyc();
        chk("R3 two slots left", free_slots, 2);
        for (int s = 0; s < 3; s++) put(s, 3'd0, 1'b1, 1'b1, 6'd0, 6'd0);
        #1;
        chk("R3 three into two refused", in_ready, 0);
        cyc();
        chk("R3 free unchanged", free_slots, 2);
        in_valid = 4'b1010; in_rdy_a = 4'hF; in_rdy_b = 4'hF;
        #1;
        chk("R3 two into two accepted", in_ready, 1);
        cyc();
        chk("R3 window now full", free_slots, 0);
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        chk("R1 reset from full", free_slots, 16);

        // R5: circular age order after the allocation pointer wraps
        do_reset();
        fill_stalled(6'd9);
        done_valid = 2'b11; done_idx[0] = 4'd0; done_idx[1] = 4'd1;
        cyc();
        done_valid = 2'b11; done_idx[0] = 4'd2; done_idx[1] = 4'd3;
        cyc();
        cyc();
        chk("R8 four freed at front", free_slots, 4);
        put(0, 3'd0, 1'b1, 1'b1, 6'd0, 6'd0);
        put(1, 3'd0, 1'b1, 1'b1, 6'd0, 6'd0);
        wb_valid[0] = 1'b1; wb_tag[0] = 6'd9;
        cyc();
        chk("R2 wrapped insert", free_slots, 2);
        chk("R5 oldest wins across wrap", iss_idx[0], 4);
        chk("R5 SA1 next oldest", iss_idx[1], 5);
        cyc();
        chk("R5 scan continues", iss_idx[0], 6);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule